// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps three status flags for an I2C controller and makes them visible to the processor as one byte. The first flag marks a continuous transfer. The second marks that the controller, acting as a slave, recognised its second 7-bit slave address. The third marks that arbitration was lost while the controller was transmitting as bus master. The shift engine, the bit timing and the address comparator are outside the block. They report to it through single-cycle event pulses and mode levels.

Software clears a flag in two steps. It must first read the byte and see that flag at 1, and it must then write 0 to that flag's bit. Each flag is a small state machine with three states. FLG_CLEAR means the flag reads 0. FLG_SET means the flag reads 1 but has not been read as 1 yet. FLG_ARMED means the flag reads 1 and has been read as 1.

The transitions are as follows:
- set: FLG_CLEAR to FLG_SET on a hardware set event.
- arm: FLG_SET to FLG_ARMED on a read that returns 1.
- drop: FLG_SET to FLG_CLEAR on a hardware clear condition with no set event in the same cycle.
- release: FLG_ARMED to FLG_CLEAR on a write of 0 or a hardware clear condition.
- re-set: FLG_ARMED to FLG_SET when a release and a set event fall in the same cycle.

The flags also depend on each other. In slave mode the continuous-transfer flag may set only while the second-address flag is 1.

Top module: `i2c_stat_flags`

## Requirements
- R1: After reset all three flags are 0 and `rd_data` reads 0x00.
- R2: `rd_data` bit 5 is the continuous-transfer flag, bit 4 is the second-address flag and bit 3 is the arbitration-lost flag. All other bits read 0. A write acts on each flag through that flag's own bit.
- R3: The second-address flag becomes 1 in the cycle after an `addr2_hit` pulse, provided `is_master`=0, `is_tx`=0 and `fmt_sel`=0. With `fmt_sel`=1, or with `is_tx`=1, the pulse has no effect.
- R4: The second-address flag clears in the cycle after `start_det`. It is held at 0 for as long as `is_master`=1.
- R5: When `is_master`=0 and `fmt_sel`=0, a `tx_empty_set` or `rx_full_set` pulse sets the continuous-transfer flag only if the second-address flag is 1. When `is_master`=1, either pulse sets it.
- R6: An `irq_clr` pulse clears the continuous-transfer flag in the next cycle.
- R7: The arbitration-lost flag sets in the cycle after a `bit_strobe` pulse with `drv_bit` not equal to `bus_bit`, provided `is_master`=1 and `is_tx`=1. It does not set when the two bits are equal, and it does not set in slave mode.
- R8: A write of 0 to a flag's bit clears that flag only after a read that returned it as 1. A write of 0 without such a read, including after a read that returned 0, leaves the flag at 1.
- R9: A write of 1 to a flag's bit has no effect. An earlier read of 1 stays valid, so a later write of 0 still clears the flag.
- R10: When a set event and a clear fall in the same cycle, the flag stays 1. It must be read as 1 again before a write of 0 clears it.
- R11: `irq_clr` has no effect on the arbitration-lost flag or on the second-address flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = master mode, 0 = slave mode |
| is_tx | input | 1 | 1 = transmitting, 0 = receiving |
| fmt_sel | input | 1 | Format select; 0 = I2C bus format |
| start_det | input | 1 | Start condition detected (pulse) |
| addr2_hit | input | 1 | First frame after start matched second slave address (pulse) |
| tx_empty_set | input | 1 | Transmit-empty flag being set (pulse) |
| rx_full_set | input | 1 | Receive-full flag being set (pulse) |
| irq_clr | input | 1 | Interface interrupt flag cleared to 0 (pulse) |
| bit_strobe | input | 1 | Bus bit sample point (pulse) |
| drv_bit | input | 1 | Bit being driven onto SDA |
| bus_bit | input | 1 | SDA level sampled at the strobe |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Flag byte (combinational from the flag registers) |

## Verification
Every flag is a single register, and `rd_data` is decoded from those registers without further storage. A set event, hardware clear or write that is present at one rising edge therefore shows on `rd_data` right after that edge, which is one cycle after the stimulus was applied. A read arms a flag at the edge where `rd_en` is high, and the matching write of 0 takes effect at the edge after that. The bench drives every input 1 ns after a rising edge and samples `rd_data` 1 ns after the next edge. Each check falls in exactly the cycle in which the requirement places the change, and never at a clock edge.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;

    // Per-flag clear-handshake state
    typedef enum logic [1:0] {
        FLG_CLEAR = 2'd0,
        FLG_SET   = 2'd1,
        FLG_ARMED = 2'd2
    } flg_state_e;

    // Flag slot indices inside the internal vectors
    localparam int IDX_CT = 0;
    localparam int IDX_SA = 1;
    localparam int IDX_AL = 2;
    localparam int NUM_FLAGS = 3;

endpackage

// File: rtl/i2c_flag_cell.sv
module i2c_flag_cell
    import i2c_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hw_set,
    input  logic hw_clr,
    input  logic rd_en,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);

    flg_state_e state_q, state_d;
    logic       sw_clr;

    assign sw_clr = wr_en && !wr_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_CLEAR: begin
                if (hw_set) state_d = FLG_SET;
            end
            FLG_SET: begin
                if (hw_clr && !hw_set) state_d = FLG_CLEAR;
                else if (rd_en && !hw_clr) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (sw_clr || hw_clr) state_d = hw_set ? FLG_SET : FLG_CLEAR;
            end
            default: state_d = FLG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q != FLG_CLEAR);
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_set |=> flag);

    // R8
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(hw_clr || (state_q == FLG_ARMED && sw_clr)));

    // R9
    keep_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FLG_ARMED && wr_en && wr_bit && !hw_clr) |=> (state_q == FLG_ARMED));

endmodule

// File: rtl/i2c_flag_events.sv
module i2c_flag_events
    import i2c_stat_pkg::*;
(
    input  logic                 is_master,
    input  logic                 is_tx,
    input  logic                 fmt_sel,
    input  logic                 start_det,
    input  logic                 addr2_hit,
    input  logic                 tx_empty_set,
    input  logic                 rx_full_set,
    input  logic                 irq_clr,
    input  logic                 bit_strobe,
    input  logic                 drv_bit,
    input  logic                 bus_bit,
    input  logic                 sa_flag,
    output logic [NUM_FLAGS-1:0] set_vec,
    output logic [NUM_FLAGS-1:0] clr_vec
);

    logic slave_rx;
    logic need_sa;
    logic xfer_evt;

    always_comb begin
        slave_rx = !is_master && !is_tx;
        need_sa  = !is_master && !fmt_sel;
        xfer_evt = tx_empty_set || rx_full_set;

        set_vec[IDX_CT] = xfer_evt && (!need_sa || sa_flag);
        clr_vec[IDX_CT] = irq_clr;

        set_vec[IDX_SA] = slave_rx && !fmt_sel && addr2_hit;
        clr_vec[IDX_SA] = start_det || is_master;

        set_vec[IDX_AL] = is_master && is_tx && bit_strobe && (drv_bit != bus_bit);
        clr_vec[IDX_AL] = 1'b0;
    end

endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
    import i2c_stat_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CT_BIT = 5,
    parameter int SA_BIT = 4,
    parameter int AL_BIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic              is_tx,
    input  logic              fmt_sel,
    input  logic              start_det,
    input  logic              addr2_hit,
    input  logic              tx_empty_set,
    input  logic              rx_full_set,
    input  logic              irq_clr,
    input  logic              bit_strobe,
    input  logic              drv_bit,
    input  logic              bus_bit,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_vec;
    logic                 unused_wr;

    assign unused_wr = ^wr_data;

    i2c_flag_events u_events (
        .is_master    (is_master),
        .is_tx        (is_tx),
        .fmt_sel      (fmt_sel),
        .start_det    (start_det),
        .addr2_hit    (addr2_hit),
        .tx_empty_set (tx_empty_set),
        .rx_full_set  (rx_full_set),
        .irq_clr      (irq_clr),
        .bit_strobe   (bit_strobe),
        .drv_bit      (drv_bit),
        .bus_bit      (bus_bit),
        .sa_flag      (flag_vec[IDX_SA]),
        .set_vec      (set_vec),
        .clr_vec      (clr_vec)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        localparam int POS = (g == IDX_CT) ? CT_BIT :
                             (g == IDX_SA) ? SA_BIT : AL_BIT;
        i2c_flag_cell u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .hw_set (set_vec[g]),
            .hw_clr (clr_vec[g]),
            .rd_en  (rd_en),
            .wr_en  (wr_en),
            .wr_bit (wr_data[POS]),
            .flag   (flag_vec[g])
        );
    end

    always_comb begin
        rd_data         = '0;
        rd_data[CT_BIT] = flag_vec[IDX_CT];
        rd_data[SA_BIT] = flag_vec[IDX_SA];
        rd_data[AL_BIT] = flag_vec[IDX_AL];
    end

    // R4
    master_sa_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_master |=> !rd_data[SA_BIT]);

    // R11
    al_irq_immune_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[AL_BIT]) |-> $past(wr_en && !wr_data[AL_BIT]));

    // R5
    ct_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[CT_BIT]) |-> $past(tx_empty_set || rx_full_set));

    // R7
    al_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && is_tx && bit_strobe && drv_bit != bus_bit) |=> rd_data[AL_BIT]);

endmodule

// File: tb/test_i2c_stat_flags.sv
module test_i2c_stat_flags;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          is_master = 1'b0, is_tx = 1'b0, fmt_sel = 1'b0;
    logic          start_det = 1'b0, addr2_hit = 1'b0;
    logic          tx_empty_set = 1'b0, rx_full_set = 1'b0, irq_clr = 1'b0;
    logic          bit_strobe = 1'b0, drv_bit = 1'b0, bus_bit = 1'b0;
    logic          rd_en = 1'b0, wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    i2c_stat_flags i_i2c_stat_flags (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .is_tx(is_tx),
        .fmt_sel(fmt_sel), .start_det(start_det), .addr2_hit(addr2_hit),
        .tx_empty_set(tx_empty_set), .rx_full_set(rx_full_set),
        .irq_clr(irq_clr), .bit_strobe(bit_strobe), .drv_bit(drv_bit),
        .bus_bit(bus_bit), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [DW-1:0] exp);
        total++;
        if (rd_data !== exp) begin
            bad++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, exp);
        end
    endtask

    task automatic pulse_idle();
        start_det = 0; addr2_hit = 0; tx_empty_set = 0; rx_full_set = 0;
        irq_clr = 0; bit_strobe = 0; rd_en = 0; wr_en = 0;
    endtask

    task automatic do_read();
        rd_en = 1; tick(); rd_en = 0;
    endtask

    task automatic do_write(logic [DW-1:0] v);
        wr_en = 1; wr_data = v; tick(); wr_en = 0;
    endtask

    task automatic clear_all();
        do_read(); do_write(8'h00);
        start_det = 1; tick(); start_det = 0;
    endtask

    task automatic set_al();
        is_master = 1; is_tx = 1; bit_strobe = 1; drv_bit = 1; bus_bit = 0;
        tick(); bit_strobe = 0; is_master = 0; is_tx = 0;
    endtask

    task automatic set_sa();
        is_master = 0; is_tx = 0; fmt_sel = 0; addr2_hit = 1; tick(); addr2_hit = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; tick(); tick(); check("R1 reset", 8'h00);
        rst_n = 1; tick(); check("R1 after release", 8'h00);
    endtask

    task automatic t_sa();
        set_sa(); check("R3 sa set / R2 bit4", 8'h10);
        tick(); check("R11 sa holds", 8'h10);
        irq_clr = 1; tick(); irq_clr = 0; check("R11 irq_clr leaves sa", 8'h10);
        start_det = 1; tick(); start_det = 0; check("R4 start clears sa", 8'h00);
        fmt_sel = 1; addr2_hit = 1; tick(); addr2_hit = 0; fmt_sel = 0;
        check("R3 fmt_sel=1 ignored", 8'h00);
        is_tx = 1; addr2_hit = 1; tick(); addr2_hit = 0; is_tx = 0;
        check("R3 transmit ignored", 8'h00);
        set_sa(); is_master = 1; tick(); check("R4 master clears sa", 8'h00);
        tick(); is_master = 0; check("R4 master holds sa low", 8'h00);
    endtask

    task automatic t_ct();
        tx_empty_set = 1; tick(); tx_empty_set = 0;
        check("R5 slave without sa no ct", 8'h00);
        set_sa();
        rx_full_set = 1; tick(); rx_full_set = 0; check("R5 slave with sa sets ct / R2", 8'h30);
        irq_clr = 1; tick(); irq_clr = 0; check("R6 irq_clr clears ct", 8'h10);
        start_det = 1; tick(); start_det = 0;
        is_master = 1; tx_empty_set = 1; tick(); tx_empty_set = 0; is_master = 0;
        check("R5 master sets ct", 8'h20);
        irq_clr = 1; tick(); irq_clr = 0; check("R6 ct cleared again", 8'h00);
    endtask

    task automatic t_al();
        is_master = 1; is_tx = 1; bit_strobe = 1; drv_bit = 1; bus_bit = 1;
        tick(); bit_strobe = 0; check("R7 equal bits no al", 8'h00);
        is_master = 0; bit_strobe = 1; bus_bit = 0; tick(); bit_strobe = 0; is_tx = 0;
        check("R7 slave mismatch ignored", 8'h00);
        set_al(); check("R7 mismatch sets al / R2 bit3", 8'h08);
        irq_clr = 1; tick(); irq_clr = 0; check("R11 irq_clr leaves al", 8'h08);
    endtask

    task automatic t_handshake();
        do_write(8'h00); check("R8 write0 without read keeps al", 8'h08);
        do_read(); do_write(8'h00); check("R8 read then write0 clears", 8'h00);
        do_read(); set_al(); do_write(8'h00);
        check("R8 read of 0 does not arm", 8'h08);
        do_read(); do_write(8'h00); check("R8 cleanup", 8'h00);
        set_sa(); rx_full_set = 1; tick(); rx_full_set = 0;
        do_read(); do_write(8'h10); check("R2 write clears only bit5", 8'h10);
        do_write(8'h00); check("R2 armed sa clears", 8'h00);
    endtask

    task automatic t_write_one();
        set_al(); do_read(); do_write(8'hFF); check("R9 write1 no effect", 8'h08);
        do_write(8'h00); check("R9 arm kept after write1", 8'h00);
    endtask

    task automatic t_set_wins();
        set_al(); do_read();
        is_master = 1; is_tx = 1; bit_strobe = 1; drv_bit = 0; bus_bit = 1;
        wr_en = 1; wr_data = 8'h00; tick();
        wr_en = 0; bit_strobe = 0; is_master = 0; is_tx = 0;
        check("R10 set wins over clear", 8'h08);
        do_write(8'h00); check("R10 needs new read", 8'h08);
        do_read(); do_write(8'h00); check("R10 cleared after re-read", 8'h00);
        set_sa(); is_master = 0; start_det = 1; addr2_hit = 1; tick();
        start_det = 0; addr2_hit = 0; check("R10 sa set beats start", 8'h10);
        clear_all(); check("R1 all clear", 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: rd_data=%02h expected=run end", rd_data);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        pulse_idle();
        tick();
        t_reset();
        t_sa();
        t_ct();
        t_al();
        t_handshake();
        t_write_one();
        t_set_wins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule